// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block runs transfers on an external parallel bus for one internal requester. A transfer starts with an address phase of one clock. During that clock the latch strobe is high and the address and attributes are valid. One or more data beats follow, each preceded by a fixed number of wait clocks. The chip select of the matching device is held low from the address phase to the last beat. Then one idle clock follows, with the chip select released and a done pulse back to the requester.

A build parameter selects one of two pin arrangements. In the shared arrangement the 32 address/data pins carry the address first and then the data. Byte lanes that the device's port does not use for data keep showing the address bits. In the split arrangement the address goes out on a separate output for the whole transfer, and the shared pins carry only data. Data always uses the upper byte lanes of the bus: one lane for an 8-bit device, two for a 16-bit device, all four for a 32-bit device. The number of beats is the operand size divided by the port width. Beat data for writes is taken from the requester one beat at a time, and the requester advances it after each beat acknowledge.

Top module: `abus_master`

## Requirements
- R1: One clock after a request is accepted, `bus_ale` is high for exactly one clock. In shared mode all four lanes are then driven with the full 32-bit request address. In split mode the shared lanes are undriven and `bus_addr` carries the address from that clock through the last data beat.
- R2: `bus_rw` is 1 for a read and 0 for a write while a transfer runs, and it rests at 1 when no transfer is active.
- R3: The select output whose bit was set in the one-hot `cs_hit` is low from the address phase through the final beat. All selects are high otherwise. The clock after the final beat is an idle clock with `done` high for one cycle, and `busy` is low the cycle after. A request is accepted only while `busy` is low.
- R4: `bus_tsiz` carries the request size code while a transfer runs. The codes are 01 byte, 10 word, 00 longword and 11 sixteen-byte line. The number of beats equals the size in bytes divided by the port width in bytes, with a minimum of 1. The port codes are 01 for 8-bit, 10 for 16-bit, and 00 or 11 for 32-bit.
- R5: `bus_tbst_n` is low for the entire transfer when it has two or more beats, and high otherwise.
- R6: Each data beat is preceded by exactly WAIT_CYCLES wait clocks. `beat_ack` is high only in the beat's data clock.
- R7: In a write beat the data lanes are driven with the low-order bytes of `beat_wdata`. An 8-bit port uses bits 31:24 for data byte 0. A 16-bit port uses bits 31:16 for the low half.
- R8: In a read beat the data lanes are undriven. `rdata` holds the data lanes shifted down and zero-extended, and it is zero in every other clock.
- R9: During wait and data clocks, lanes outside the data lanes are driven with the matching address byte in shared mode and undriven in split mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Request a transfer (taken when idle) |
| req_addr | input | 32 | Transfer start address |
| req_size | input | 2 | Operand size code |
| req_read | input | 1 | 1 read, 0 write |
| beat_wdata | input | 32 | Write data of the current beat, right-aligned |
| cs_hit | input | NUM_CS | One-hot matching chip select |
| cs_port | input | 2 | Port width of the matching device |
| busy | output | 1 | Transfer in progress |
| beat_ack | output | 1 | Data clock of a beat |
| done | output | 1 | Transfer finished pulse |
| rdata | output | 32 | Read data of the current beat, right-aligned |
| bus_ad_out | output | 32 | Shared pin output values |
| bus_ad_oe | output | 4 | Per-lane output enable of shared pins |
| bus_ad_in | input | 32 | Shared pin input values |
| bus_addr | output | 32 | Separate address output (split mode) |
| bus_ale | output | 1 | Address latch strobe |
| bus_rw | output | 1 | Direction |
| bus_tbst_n | output | 1 | Burst in progress, active low |
| bus_tsiz | output | 2 | Transfer size attribute |
| bus_cs_n | output | NUM_CS | Chip selects, active low |

## Verification
The bench builds two copies of the block. One is in shared mode with WAIT_CYCLES = 2 and the other in split mode with WAIT_CYCLES = 0. The first shows the address staying on unused lanes through several wait clocks. The second runs beats back to back with the address on its own output. Both copies run single-beat transfers and bursts of 2, 4, 8 and 16 beats on 8-, 16- and 32-bit ports, in both directions.

// File: rtl/abus_pkg.sv
package abus_pkg;

    localparam int BUS_W   = 32;
    localparam int LANES   = BUS_W / 8;
    localparam int BEATS   = 16;
    localparam int BEAT_W  = $clog2(BEATS);

    localparam logic [1:0] SZ_LONG = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;
    localparam logic [1:0] SZ_LINE = 2'b11;

    localparam logic [1:0] PW_32  = 2'b00;
    localparam logic [1:0] PW_8   = 2'b01;
    localparam logic [1:0] PW_16  = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_DATA,
        ST_GAP
    } abus_state_e;

endpackage

// File: rtl/abus_beat_calc.sv
module abus_beat_calc
    import abus_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [1:0]        port,
    output logic [BEAT_W-1:0] beats_m1,
    output logic [LANES-1:0]  data_lanes,
    output logic              burst
);

    logic [2:0] size_log;
    logic [2:0] port_log;
    logic [2:0] ratio_log;

    always_comb begin
        case (size)
            SZ_BYTE: size_log = 3'd0;
            SZ_WORD: size_log = 3'd1;
            SZ_LONG: size_log = 3'd2;
            default: size_log = 3'd4;
        endcase
        case (port)
            PW_8:    port_log = 3'd0;
            PW_16:   port_log = 3'd1;
            default: port_log = 3'd2;
        endcase
        ratio_log = (size_log > port_log) ? (size_log - port_log) : 3'd0;
        beats_m1  = BEAT_W'((5'd1 << ratio_log) - 5'd1);
        burst     = (ratio_log != 3'd0);
        case (port)
            PW_8:    data_lanes = 4'b1000;
            PW_16:   data_lanes = 4'b1100;
            default: data_lanes = 4'b1111;
        endcase
    end

endmodule

// File: rtl/abus_lane_route.sv
module abus_lane_route
    import abus_pkg::*;
#(
    parameter bit MUXED = 1'b1
) (
    input  logic              addr_phase,
    input  logic              data_phase,
    input  logic              data_clock,
    input  logic              is_read,
    input  logic [LANES-1:0]  data_lanes,
    input  logic [BUS_W-1:0]  addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  ad_in,
    output logic [BUS_W-1:0]  ad_out,
    output logic [LANES-1:0]  ad_oe,
    output logic [BUS_W-1:0]  rdata
);

    logic [4:0]        shift;
    logic [BUS_W-1:0]  wplaced;

    always_comb begin
        if (data_lanes[0])      shift = 5'd0;
        else if (data_lanes[2]) shift = 5'd16;
        else                    shift = 5'd24;
        wplaced = wdata << shift;
        rdata   = (data_clock && is_read) ? (ad_in >> shift) : '0;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic       use_data;
        logic       keep_addr;
        assign use_data  = data_phase && data_lanes[l];
        assign keep_addr = MUXED && (addr_phase || (data_phase && !data_lanes[l]));
        assign ad_oe[l]  = keep_addr || (use_data && !is_read);
        assign ad_out[8*l +: 8] = keep_addr ? addr[8*l +: 8] :
                                  (use_data && !is_read) ? wplaced[8*l +: 8] : 8'h00;
    end

endmodule

// File: rtl/abus_master.sv
module abus_master
    import abus_pkg::*;
#(
    parameter int NUM_CS      = 6,
    parameter bit MUXED       = 1'b1,
    parameter int WAIT_W      = 4,
    parameter int WAIT_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [31:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_read,
    input  logic [31:0]       beat_wdata,
    input  logic [NUM_CS-1:0] cs_hit,
    input  logic [1:0]        cs_port,
    output logic              busy,
    output logic              beat_ack,
    output logic              done,
    output logic [31:0]       rdata,
    output logic [31:0]       bus_ad_out,
    output logic [3:0]        bus_ad_oe,
    input  logic [31:0]       bus_ad_in,
    output logic [31:0]       bus_addr,
    output logic              bus_ale,
    output logic              bus_rw,
    output logic              bus_tbst_n,
    output logic [1:0]        bus_tsiz,
    output logic [NUM_CS-1:0] bus_cs_n
);

    localparam bit                NO_WAIT   = (WAIT_CYCLES == 0);
    localparam logic [WAIT_W-1:0] WAIT_LOAD = NO_WAIT ? '0 : WAIT_W'(WAIT_CYCLES - 1);

    typedef struct packed {
        abus_state_e        state;
        logic [BUS_W-1:0]   addr;
        logic [1:0]         size;
        logic               read;
        logic [NUM_CS-1:0]  cs;
        logic [LANES-1:0]   lanes;
        logic               burst;
        logic [BEAT_W-1:0]  beats_left;
        logic [WAIT_W-1:0]  wcnt;
    } abus_regs_t;

    abus_regs_t r_d, r_q;

    logic [BEAT_W-1:0] calc_beats_m1;
    logic [LANES-1:0]  calc_lanes;
    logic              calc_burst;

    abus_beat_calc u_calc (
        .size       (req_size),
        .port       (cs_port),
        .beats_m1   (calc_beats_m1),
        .data_lanes (calc_lanes),
        .burst      (calc_burst)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (req_start) begin
                    r_d.state      = ST_ADDR;
                    r_d.addr       = req_addr;
                    r_d.size       = req_size;
                    r_d.read       = req_read;
                    r_d.cs         = cs_hit;
                    r_d.lanes      = calc_lanes;
                    r_d.burst      = calc_burst;
                    r_d.beats_left = calc_beats_m1;
                end
            end
            ST_ADDR: begin
                r_d.state = NO_WAIT ? ST_DATA : ST_WAIT;
                r_d.wcnt  = WAIT_LOAD;
            end
            ST_WAIT: begin
                if (r_q.wcnt == '0) r_d.state = ST_DATA;
                else                r_d.wcnt  = r_q.wcnt - 1'b1;
            end
            ST_DATA: begin
                if (r_q.beats_left == '0) begin
                    r_d.state = ST_GAP;
                end else begin
                    r_d.beats_left = r_q.beats_left - 1'b1;
                    r_d.state      = NO_WAIT ? ST_DATA : ST_WAIT;
                    r_d.wcnt       = WAIT_LOAD;
                end
            end
            ST_GAP:  r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, addr: '0, size: '0, read: 1'b1, cs: '0,
                     lanes: '0, burst: 1'b0, beats_left: '0, wcnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    logic in_xfer;
    logic data_phase;

    assign in_xfer    = (r_q.state == ST_ADDR) || (r_q.state == ST_WAIT) || (r_q.state == ST_DATA);
    assign data_phase = (r_q.state == ST_WAIT) || (r_q.state == ST_DATA);

    assign busy       = (r_q.state != ST_IDLE);
    assign beat_ack   = (r_q.state == ST_DATA);
    assign done       = (r_q.state == ST_GAP);
    assign bus_ale    = (r_q.state == ST_ADDR);
    assign bus_rw     = in_xfer ? r_q.read : 1'b1;
    assign bus_tbst_n = in_xfer ? !r_q.burst : 1'b1;
    assign bus_tsiz   = in_xfer ? r_q.size : 2'b00;
    assign bus_cs_n   = in_xfer ? ~r_q.cs : '1;
    assign bus_addr   = (!MUXED && in_xfer) ? r_q.addr : '0;

    abus_lane_route #(.MUXED(MUXED)) u_route (
        .addr_phase (r_q.state == ST_ADDR),
        .data_phase (data_phase),
        .data_clock (r_q.state == ST_DATA),
        .is_read    (r_q.read),
        .data_lanes (r_q.lanes),
        .addr       (r_q.addr),
        .wdata      (beat_wdata),
        .ad_in      (bus_ad_in),
        .ad_out     (bus_ad_out),
        .ad_oe      (bus_ad_oe),
        .rdata      (rdata)
    );

endmodule

// File: rtl/abus_master_chk.sv
module abus_master_chk #(
    parameter int NUM_CS = 6,
    parameter bit MUXED  = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              beat_ack,
    input logic              done,
    input logic [3:0]        bus_ad_oe,
    input logic              bus_ale,
    input logic              bus_rw,
    input logic              bus_tbst_n,
    input logic [NUM_CS-1:0] bus_cs_n
);

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale); // R1

    AST_ALE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_ad_oe == (MUXED ? 4'hF : 4'h0))); // R1

    AST_RW_REST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> bus_rw); // R2

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n)); // R3

    AST_DONE_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&bus_cs_n && busy)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_BURST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ale && !(&bus_cs_n)) |-> $stable(bus_tbst_n)); // R5

    AST_ACK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ack |-> !(&bus_cs_n)); // R6

    AST_READ_LANE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ack && bus_rw) |-> !bus_ad_oe[3]); // R8

endmodule

bind abus_master abus_master_chk #(.NUM_CS(NUM_CS), .MUXED(MUXED)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .beat_ack   (beat_ack),
    .done       (done),
    .bus_ad_oe  (bus_ad_oe),
    .bus_ale    (bus_ale),
    .bus_rw     (bus_rw),
    .bus_tbst_n (bus_tbst_n),
    .bus_cs_n   (bus_cs_n)
);

// File: tb/abus_master_test.sv
`timescale 1ns/1ps

module abus_harness #(
    parameter bit MUXED       = 1'b1,
    parameter int WAIT_CYCLES = 0,
    parameter int NUM_CS      = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic finished
);

    logic              req_start, req_read, busy, beat_ack, done;
    logic              bus_ale, bus_rw, bus_tbst_n;
    logic [31:0]       req_addr, beat_wdata, rdata, bus_ad_out, bus_ad_in, bus_addr;
    logic [1:0]        req_size, cs_port, bus_tsiz;
    logic [3:0]        bus_ad_oe;
    logic [NUM_CS-1:0] cs_hit, bus_cs_n;

    abus_master #(.NUM_CS(NUM_CS), .MUXED(MUXED), .WAIT_CYCLES(WAIT_CYCLES)) uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
        .req_size(req_size), .req_read(req_read), .beat_wdata(beat_wdata),
        .cs_hit(cs_hit), .cs_port(cs_port), .busy(busy), .beat_ack(beat_ack),
        .done(done), .rdata(rdata), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in), .bus_addr(bus_addr), .bus_ale(bus_ale),
        .bus_rw(bus_rw), .bus_tbst_n(bus_tbst_n), .bus_tsiz(bus_tsiz),
        .bus_cs_n(bus_cs_n)
    );

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        logic [3:0]  oe;
        logic [31:0] out;
        logic [31:0] rd;
    } beat_exp_t;

    beat_exp_t expq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s (mux=%0d): actual %h expected %h", req, what, MUXED, act, exp);
        end
    endtask

    function automatic logic [31:0] wpat(input int b, input logic [31:0] a);
        return 32'h5A00_0000 ^ (32'(b) * 32'h0103_0507) ^ {a[7:0], a[15:8], a[23:16], a[31:24]};
    endfunction

    function automatic logic [31:0] rpat(input int b, input logic [31:0] a);
        return 32'hC300_0000 + (32'(b) * 32'h1122_3344) + a;
    endfunction

    function automatic logic [31:0] lane_bits(input logic [3:0] m);
        return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    endfunction

    // scoreboard monitor: compares each data beat with the queued expectation
    always @(negedge clk) begin
        if (rst_n && beat_ack) begin
            if (expq.size() == 0) begin
                check(1'b0, "R6", "beat with empty scoreboard", 32'd1, 32'd0);
            end else begin
                beat_exp_t e;
                logic [31:0] m;
                e = expq.pop_front();
                m = lane_bits(e.oe);
                check(bus_ad_oe == e.oe, "R9", "lane enables", {28'd0, bus_ad_oe}, {28'd0, e.oe});
                check((bus_ad_out & m) == (e.out & m), "R7", "driven lanes", bus_ad_out & m, e.out & m);
                check(rdata == e.rd, "R8", "read data", rdata, e.rd);
            end
        end
    end

    task automatic xfer(input logic [31:0] addr, input logic [1:0] size,
                        input logic [1:0] port, input bit rd, input int csx);
        int szb, pb, beats, sh;
        logic [3:0] dl;
        logic [NUM_CS-1:0] csn_exp;
        szb = (size == 2'b01) ? 1 : (size == 2'b10) ? 2 : (size == 2'b00) ? 4 : 16;
        pb  = (port == 2'b01) ? 1 : (port == 2'b10) ? 2 : 4;
        beats = (szb > pb) ? szb / pb : 1;
        dl  = (pb == 1) ? 4'b1000 : (pb == 2) ? 4'b1100 : 4'b1111;
        sh  = (4 - pb) * 8;
        csn_exp = ~(NUM_CS'(1) << csx);
        for (int b = 0; b < beats; b++) begin
            beat_exp_t e;
            e.oe  = (rd ? 4'b0000 : dl) | (MUXED ? ~dl : 4'b0000);
            e.out = (MUXED ? (addr & ~lane_bits(dl)) : 32'd0) |
                    (rd ? 32'd0 : ((wpat(b, addr) << sh) & lane_bits(dl)));
            e.rd  = rd ? (rpat(b, addr) >> sh) : 32'd0;
            expq.push_back(e);
        end
        @(posedge clk); #1;
        req_start = 1'b1; req_addr = addr; req_size = size; req_read = rd;
        cs_hit = NUM_CS'(1) << csx; cs_port = port;
        @(posedge clk); #1;
        req_start = 1'b0; req_addr = 32'hFFFF_FFFF; cs_hit = '0; cs_port = 2'b01;
        @(negedge clk);
        check(bus_ale == 1'b1, "R1", "ale in address phase", {31'd0, bus_ale}, 32'd1);
        if (MUXED)
            check(bus_ad_oe == 4'hF && bus_ad_out == addr, "R1", "address on lanes", bus_ad_out, addr);
        else
            check(bus_ad_oe == 4'h0 && bus_addr == addr, "R1", "split address", bus_addr, addr);
        check(bus_cs_n == csn_exp, "R3", "select in address phase", 32'(bus_cs_n), 32'(csn_exp));
        check(bus_rw == rd, "R2", "direction", {31'd0, bus_rw}, {31'd0, rd});
        check(bus_tsiz == size, "R4", "size attribute", {30'd0, bus_tsiz}, {30'd0, size});
        check(bus_tbst_n == (beats == 1), "R5", "burst in address phase",
              {31'd0, bus_tbst_n}, {31'd0, beats == 1});
        for (int b = 0; b < beats; b++) begin
            for (int c = 0; c <= WAIT_CYCLES; c++) begin
                @(posedge clk); #1;
                if (c == 0) begin
                    beat_wdata = wpat(b, addr);
                    bus_ad_in  = rpat(b, addr);
                end
                @(negedge clk);
                check(beat_ack == (c == WAIT_CYCLES), "R6", "beat timing",
                      {31'd0, beat_ack}, {31'd0, c == WAIT_CYCLES});
                check(bus_ale == 1'b0 && bus_cs_n == csn_exp, "R3", "select held",
                      32'(bus_cs_n), 32'(csn_exp));
                check(bus_tbst_n == (beats == 1), "R5", "burst held",
                      {31'd0, bus_tbst_n}, {31'd0, beats == 1});
                if (!MUXED)
                    check(bus_addr == addr, "R1", "split address held", bus_addr, addr);
            end
        end
        @(posedge clk); #1;
        @(negedge clk);
        check(done == 1'b1 && &bus_cs_n, "R3", "idle clock with done", {31'd0, done}, 32'd1);
        check(beat_ack == 1'b0 && expq.size() == 0, "R4", "beat count",
              32'(expq.size()), 32'd0);
        check(bus_rw == 1'b1 && bus_tbst_n == 1'b1, "R2", "rest levels",
              {30'd0, bus_rw, bus_tbst_n}, 32'd3);
        @(posedge clk); #1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R3", "back to idle", {30'd0, busy, done}, 32'd0);
    endtask

    initial begin
        finished   = 1'b0;
        req_start  = 1'b0; req_addr = '0; req_size = '0; req_read = 1'b0;
        beat_wdata = '0;   cs_hit = '0;   cs_port = '0;  bus_ad_in = '0;
        @(posedge rst_n);
        @(negedge clk);
        check(busy == 1'b0 && bus_ale == 1'b0 && &bus_cs_n && bus_ad_oe == 4'h0,
              "R3", "reset state", {28'd0, bus_ad_oe}, 32'd0);
        check(bus_rw == 1'b1 && bus_tbst_n == 1'b1, "R2", "reset rest levels",
              {30'd0, bus_rw, bus_tbst_n}, 32'd3);
        xfer(32'h1234_5679, 2'b01, 2'b00, 1'b1, 0);   // byte read, 32-bit port
        xfer(32'hA0B0_C0D4, 2'b11, 2'b01, 1'b0, 5);   // line write, 8-bit port, 16 beats
        xfer(32'h0000_8F02, 2'b00, 2'b10, 1'b1, 2);   // long read, 16-bit port, 2 beats
        xfer(32'h7654_3210, 2'b10, 2'b00, 1'b0, 1);   // word write, 32-bit port
        xfer(32'hDEAD_BEE0, 2'b11, 2'b11, 1'b1, 3);   // line read, 32-bit port, 4 beats
        xfer(32'h0101_0A0A, 2'b10, 2'b01, 1'b1, 4);   // word read, 8-bit port, 2 beats
        xfer(32'hFEDC_BA98, 2'b00, 2'b01, 1'b0, 0);   // long write, 8-bit port, 4 beats
        xfer(32'h3333_CCCC, 2'b11, 2'b10, 1'b0, 2);   // line write, 16-bit port, 8 beats
        finished = 1'b1;
    end

endmodule

module abus_master_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fin_mux, fin_split;
    int   cycles = 0;
    int   wd_errors = 0;

    always #2.5 clk = ~clk;

    abus_harness #(.MUXED(1'b1), .WAIT_CYCLES(2)) h_mux   (.clk(clk), .rst_n(rst_n), .finished(fin_mux));
    abus_harness #(.MUXED(1'b0), .WAIT_CYCLES(0)) h_split (.clk(clk), .rst_n(rst_n), .finished(fin_split));

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        while (!(fin_mux && fin_split) && cycles < 20000) @(posedge clk);
        if (!(fin_mux && fin_split)) begin
            wd_errors = 1;
            $display("FAIL R3 watchdog: actual run still busy, expected completion");
        end
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors",
                 h_mux.n_checks + h_split.n_checks + wd_errors,
                 h_mux.n_errors + h_split.n_errors + wd_errors);
        $finish;
    end

endmodule